// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block sits between eight shared, level-sensitive interrupt lines (labelled A to H, index 0 to 7) and two kinds of interrupt controller: a 16-input legacy controller and a 24-input advanced controller. For the legacy side, every shared line has its own routing byte. That byte either names a legacy input or takes the line off the legacy side altogether. When several lines name the same legacy input, their levels are ORed together onto it. The advanced side ignores the routing bytes and wires each shared line to its own fixed input.

A separate system-control interrupt (SCI) level can be steered onto one of five inputs by a code held in a control byte. The SCI is ORed into the advanced input it selects. If that input number is below 16, the SCI also reaches the legacy input with the same number. Software writes the routing and control bytes through a simple write port. After reset, every shared line is off the legacy side and the SCI targets line 9.

Top module: `pirq_irq_router`

## Requirements
- R1: In the cycle after synchronous reset, both output vectors are zero. Every routing byte resets to 0x80, the control byte resets to 0x00 (SCI on line 9), and the stored SCI level resets to 0.
- R2: Routing byte bit 7 is the disable flag and bits 6:0 hold a legacy input number. Legacy output k is the OR of every shared line whose byte has bit 7 clear and bits 6:0 equal to k.
- R3: A shared line whose routing byte has bit 7 set has no effect on any legacy output.
- R4: A shared line whose byte has bit 7 clear but a number of 16 or more in bits 6:0 has no effect on any legacy output.
- R5: Advanced output 16+n follows shared line n, whatever the routing bytes hold.
- R6: Control byte bits 2:0 select the SCI target. The codes map as 0 to line 9, 1 to line 10, 2 to line 11, 4 to line 20 and 5 to line 21. Codes 3, 6 and 7 are reserved, and with one of them the SCI drives no output.
- R7: The stored SCI level is ORed into the selected advanced output, and also into the legacy output with the same number when that number is below 16.
- R8: Outputs are registered. A shared-line change appears after the next rising edge. An SCI change, or a configuration write, appears after the second rising edge, because it is first captured in a register.
- R9: Advanced outputs 0 to 8 and 12 to 15 are always zero.
- R10: Write select values 0 to 7 address the routing bytes of lines A to H, and value 8 addresses the control byte. Writes with select values 9 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pirq_lvl | input | 8 | Shared interrupt line levels, bit n is line n |
| sci_in | input | 1 | System-control interrupt level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration byte select |
| cfg_wdata | input | 8 | Configuration write data |
| legacy_irq | output | 16 | Legacy controller inputs |
| apic_irq | output | 24 | Advanced controller inputs |

## Verification
Every cycle, the assertions check four things: the fixed one-to-one mapping of shared lines onto advanced inputs 16 to 23, that the unreachable advanced inputs stay low, that all outputs are quiet when no source is active, and that legacy outputs never outnumber the active sources plus the SCI. Other behaviours depend on the contents of the routing and control bytes, and only the bench's scenarios show them. These are the wired-OR sharing of a legacy input, the two ways a route can be disabled, the reserved SCI codes, the writes that are ignored, and the exact one- and two-edge latencies.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

    localparam int ROUTE_NUM_W = 7;
    localparam int LINE_W      = 5;

    typedef struct packed {
        logic                   dis;
        logic [ROUTE_NUM_W-1:0] num;
    } route_t;

    typedef enum logic [2:0] {
        SCI_TO_9   = 3'd0,
        SCI_TO_10  = 3'd1,
        SCI_TO_11  = 3'd2,
        SCI_RSV_3  = 3'd3,
        SCI_TO_20  = 3'd4,
        SCI_TO_21  = 3'd5,
        SCI_RSV_6  = 3'd6,
        SCI_RSV_7  = 3'd7
    } sci_code_e;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
    } sci_tgt_t;

    localparam logic [7:0] ROUTE_RESET = 8'h80;
    localparam logic [7:0] CTRL_RESET  = 8'h00;

    function automatic sci_tgt_t sci_decode(input logic [2:0] code);
        sci_tgt_t t;
        t.valid = 1'b1;
        case (sci_code_e'(code))
            SCI_TO_9:  t.line = LINE_W'(9);
            SCI_TO_10: t.line = LINE_W'(10);
            SCI_TO_11: t.line = LINE_W'(11);
            SCI_TO_20: t.line = LINE_W'(20);
            SCI_TO_21: t.line = LINE_W'(21);
            default: begin
                t.valid = 1'b0;
                t.line  = '0;
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = 8,
    parameter int SEL_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [SEL_W-1:0]         sel,
    input  logic [7:0]               wdata,
    input  logic                     sci_in,
    output route_t [N_PIRQ-1:0]      routes,
    output sci_tgt_t                 sci_tgt,
    output logic                     sci_q
);
    localparam int CTRL_SEL = N_PIRQ;

    logic [7:0] ctrl_q;

    for (genvar n = 0; n < N_PIRQ; n++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst) begin
                routes[n] <= route_t'(ROUTE_RESET);
            end else if (we && sel == SEL_W'(n)) begin
                routes[n] <= route_t'(wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (we && sel == SEL_W'(CTRL_SEL)) begin
            ctrl_q <= wdata;
        end
    end

    // SCI level captured as a boolean; register only moves on a real change
    always_ff @(posedge clk) begin
        if (rst) begin
            sci_q <= 1'b0;
        end else if (sci_in != sci_q) begin
            sci_q <= sci_in;
        end
    end

    assign sci_tgt = sci_decode(ctrl_q[2:0]);

endmodule

// File: rtl/pirq_legacy_merge.sv
module pirq_legacy_merge
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = 8,
    parameter int N_LEG  = 16
) (
    input  logic [N_PIRQ-1:0]    pirq,
    input  route_t [N_PIRQ-1:0]  routes,
    input  logic                 sci_q,
    input  sci_tgt_t             sci_tgt,
    output logic [N_LEG-1:0]     leg_nxt
);
    for (genvar l = 0; l < N_LEG; l++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int n = 0; n < N_PIRQ; n++) begin
                // a number of N_LEG or above never matches any line index
                if (pirq[n] && !routes[n].dis && routes[n].num == ROUTE_NUM_W'(l)) begin
                    hit = 1'b1;
                end
            end
            if (sci_q && sci_tgt.valid && sci_tgt.line == LINE_W'(l)) begin
                hit = 1'b1;
            end
        end
        assign leg_nxt[l] = hit;
    end

endmodule

// File: rtl/pirq_apic_merge.sv
module pirq_apic_merge
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = 8,
    parameter int N_LEG  = 16,
    parameter int N_APIC = 24
) (
    input  logic [N_PIRQ-1:0] pirq,
    input  logic              sci_q,
    input  sci_tgt_t          sci_tgt,
    output logic [N_APIC-1:0] apic_nxt
);
    for (genvar g = 0; g < N_APIC; g++) begin : g_line
        localparam int PIDX = g - N_LEG;
        logic base;
        if (PIDX >= 0 && PIDX < N_PIRQ) begin : g_fixed
            assign base = pirq[PIDX];
        end else begin : g_none
            assign base = 1'b0;
        end
        assign apic_nxt[g] = base | (sci_q && sci_tgt.valid && sci_tgt.line == LINE_W'(g));
    end

endmodule

// File: rtl/pirq_irq_router.sv
module pirq_irq_router
    import pirq_router_pkg::*;
#(
    parameter int N_PIRQ = 8,
    parameter int N_LEG  = 16,
    parameter int N_APIC = 24,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_PIRQ-1:0] pirq_lvl,
    input  logic              sci_in,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [N_LEG-1:0]  legacy_irq,
    output logic [N_APIC-1:0] apic_irq
);
    route_t [N_PIRQ-1:0] routes;
    sci_tgt_t            sci_tgt;
    logic                sci_q;
    logic [N_LEG-1:0]    leg_nxt;
    logic [N_APIC-1:0]   apic_nxt;

    pirq_route_regs #(.N_PIRQ(N_PIRQ), .SEL_W(SEL_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .sci_in (sci_in),
        .routes (routes),
        .sci_tgt(sci_tgt),
        .sci_q  (sci_q)
    );

    pirq_legacy_merge #(.N_PIRQ(N_PIRQ), .N_LEG(N_LEG)) u_leg (
        .pirq   (pirq_lvl),
        .routes (routes),
        .sci_q  (sci_q),
        .sci_tgt(sci_tgt),
        .leg_nxt(leg_nxt)
    );

    pirq_apic_merge #(.N_PIRQ(N_PIRQ), .N_LEG(N_LEG), .N_APIC(N_APIC)) u_apic (
        .pirq    (pirq_lvl),
        .sci_q   (sci_q),
        .sci_tgt (sci_tgt),
        .apic_nxt(apic_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            legacy_irq <= '0;
            apic_irq   <= '0;
        end else begin
            legacy_irq <= leg_nxt;
            apic_irq   <= apic_nxt;
        end
    end

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
    parameter int N_PIRQ = 8,
    parameter int N_LEG  = 16,
    parameter int N_APIC = 24
) (
    input logic              clk,
    input logic              rst,
    input logic [N_PIRQ-1:0] pirq_lvl,
    input logic              sci_q,
    input logic [N_LEG-1:0]  legacy_irq,
    input logic [N_APIC-1:0] apic_irq
);
    // R1: reset leaves both output vectors quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (legacy_irq == '0 && apic_irq == '0));

    // R5: each shared line reaches its own advanced input
    for (genvar n = 0; n < N_PIRQ; n++) begin : g_fixed
        p_apic_fixed_r5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(pirq_lvl[n])) |-> apic_irq[N_LEG + n]);
    end

    // R9: advanced inputs no source can reach stay low
    p_apic_unused_r9: assert property (@(posedge clk) disable iff (rst)
        (apic_irq[8:0] == '0 && apic_irq[15:12] == '0));

    // R7: with no source active, nothing is driven
    p_no_source_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sci_q) && $past(pirq_lvl) == '0)
            |-> (legacy_irq == '0 && apic_irq == '0));

    // R2: legacy outputs cannot outnumber active sources
    p_leg_bound_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(legacy_irq) <= $countones($past(pirq_lvl)) + 1));

endmodule

bind pirq_irq_router pirq_router_chk #(.N_PIRQ(N_PIRQ), .N_LEG(N_LEG), .N_APIC(N_APIC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pirq_lvl  (pirq_lvl),
    .sci_q     (sci_q),
    .legacy_irq(legacy_irq),
    .apic_irq  (apic_irq)
);

// File: tb/tb_pirq_irq_router.sv
module tb_pirq_irq_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pirq_lvl = '0;
    logic        sci_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] legacy_irq;
    logic [23:0] apic_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] m_rt [8];
    logic [7:0] m_ctrl;

    always #5 clk = ~clk;

    pirq_irq_router dut (
        .clk(clk), .rst(rst), .pirq_lvl(pirq_lvl), .sci_in(sci_in),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .legacy_irq(legacy_irq), .apic_irq(apic_irq)
    );

    function automatic int sci_line(logic [2:0] c);
        case (c)
            3'd0: return 9;
            3'd1: return 10;
            3'd2: return 11;
            3'd4: return 20;
            3'd5: return 21;
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] exp_leg(logic [7:0] p, logic s);
        logic [15:0] r = '0;
        int sl = sci_line(m_ctrl[2:0]);
        for (int n = 0; n < 8; n++)
            if (p[n] && !m_rt[n][7] && m_rt[n][6:0] < 16) r[m_rt[n][3:0]] = 1'b1;
        if (s && sl >= 0 && sl < 16) r[sl] = 1'b1;
        return r;
    endfunction

    function automatic logic [23:0] exp_apic(logic [7:0] p, logic s);
        logic [23:0] r = '0;
        int sl = sci_line(m_ctrl[2:0]);
        r[23:16] = p;
        if (s && sl >= 0) r[sl] = 1'b1;
        return r;
    endfunction

    task automatic check(string req, logic [39:0] act, logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] s, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s < 8) m_rt[s] = d;
        else if (s == 8) m_ctrl = d;   // R10: selects 9..15 ignored in model
    endtask

    task automatic settle_check(string req);
        repeat (3) @(negedge clk);
        check(req, {apic_irq, legacy_irq}, {exp_apic(pirq_lvl, sci_in), exp_leg(pirq_lvl, sci_in)});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < 8; i++) m_rt[i] = 8'h80;
        m_ctrl = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, all quiet
        check("R1 reset outputs", {apic_irq, legacy_irq}, 40'h0);
        // R1/R3: defaults disable legacy routing; R5 advanced still follows
        pirq_lvl = 8'hFF;
        settle_check("R1 R3 R5 default routes");
        // R1: default SCI target is line 9
        pirq_lvl = 8'h00; sci_in = 1'b1;
        settle_check("R1 R7 default SCI line 9");
        sci_in = 1'b0;

        // R2: two lines share legacy input 5
        wr(4'd0, 8'h05); wr(4'd6, 8'h05);
        pirq_lvl = 8'h40;
        settle_check("R2 shared line G");
        pirq_lvl = 8'h41;
        settle_check("R2 shared lines A and G");

        // R8: shared-line change visible after one edge
        pirq_lvl = 8'h00;
        repeat (3) @(negedge clk);
        pirq_lvl = 8'h01;
        @(negedge clk);
        check("R8 pirq one edge", {24'h0, legacy_irq}, {24'h0, 16'h0020});
        // R8: SCI needs two edges
        sci_in = 1'b1;
        @(negedge clk);
        check("R8 sci not yet", {24'h0, legacy_irq}, {24'h0, 16'h0020});
        @(negedge clk);
        check("R8 sci after two", {24'h0, legacy_irq}, {24'h0, 16'h0220});
        sci_in = 1'b0; pirq_lvl = 8'h00;

        // R4: enabled but number 16 and 0x7F
        wr(4'd1, 8'h10); wr(4'd2, 8'h7F);
        pirq_lvl = 8'h06;
        settle_check("R4 number >= 16");
        // R3: disable flag set with low number
        wr(4'd3, 8'h83);
        pirq_lvl = 8'h08;
        settle_check("R3 disabled route");

        // R6: each SCI code
        pirq_lvl = 8'h00; sci_in = 1'b1;
        for (int c = 0; c < 8; c++) begin
            wr(4'd8, 8'(c));
            settle_check("R6 R7 sci code");
        end
        // R6: reserved code explicit
        wr(4'd8, 8'h03);
        repeat (3) @(negedge clk);
        check("R6 reserved code drives nothing", {apic_irq, legacy_irq}, 40'h0);
        sci_in = 1'b0;

        // R10: ignored selects do not disturb routing
        wr(4'd8, 8'h01);
        for (int s = 9; s < 16; s++) wr(4'(s), 8'h00);
        pirq_lvl = 8'h08; sci_in = 1'b1;
        settle_check("R10 ignored selects");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int k = $urandom_range(0, 3);
            logic [7:0] d;
            if (k == 0) d = {4'h0, 4'($urandom)};
            else if (k == 1) d = {1'b0, 7'($urandom)};
            else d = 8'($urandom);
            wr(4'($urandom_range(0, 15)), d);
            pirq_lvl = 8'($urandom);
            sci_in = 1'($urandom);
            settle_check("R2 R5 R7 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule